// File: doc/BRIEF.md
# Counter Parameter Guard with Divisor Restore

This block watches a stream of decoded bus transfers and protects a peripheral counter that paces a data acquisition path. The counter's enable bit is bit 0 of its control register, found at offset 0x220 from a programmable base address. Its divisor register is found at offset 0x228. The guard keeps its own copy of the enable bit. It also keeps a shadow of the last legal divisor value, and runs a small two-state automaton over the writes to the control register.

When the divisor is changed while the counter runs, the guard raises a one-cycle flag. It also queues a recovery write that puts the shadowed divisor back at base + 0x228. The recovery write uses the low two byte lanes. The recovery requests leave through a valid/ready stream. Once `rec_valid` is high, the request (`rec_addr`, `rec_data`, `rec_be`) holds steady until `rec_ready` is seen high at a clock edge, and the requests come out in the order they were queued. When the master stalls and the queue is full, a new request is dropped and an overflow pulse is raised.

A control write that comes directly after an enable, and that is not a disable, is flagged as a forbidden change. The event input has no ready signal, because a snooped bus cannot be stalled: every transfer presented with `evt_valid` is consumed in that cycle.

Top module: `reg_guard_mon`

## Requirements
- R1: After reset, `div_viol`, `ctrl_viol`, `rec_ovf` and `rec_valid` are low, the enable copy is clear, the automaton is in its start state, and the divisor shadow is 0.
- R2: Only write transfers (`evt_write`=1) whose address equals base+0x220 (control) or base+0x228 (divisor) take effect. Reads and other addresses change no state.
- R3: The enable copy takes the value of bit 0 of each control write.
- R4: A divisor write with the enable copy set and the low 16 data bits different from the shadow pulses `div_viol`. It also queues a request with `rec_addr` = base+0x228, `rec_data` = the shadow, and `rec_be` = 0b0011. The shadow keeps its value.
- R5: A divisor write with the enable copy clear updates the shadow to the written value and raises nothing. A divisor write whose value equals the shadow raises nothing.
- R6: Control writes are classified against the enable copy. A write that sets bit 0 from clear is an enable. A write that clears bit 0 from set is a disable. Any other control write is a modify. A modify that follows an enable with no disable in between pulses `ctrl_viol`.
- R7: After flagging, the automaton returns to its start state, so a further modify raises nothing. An enable followed by a disable raises nothing.
- R8: `div_viol`, `ctrl_viol` and a new `rec_valid` appear after the second rising edge following the transfer, which is within 4 cycles.
- R9: While `rec_valid` is high and `rec_ready` is low, the request payload stays stable. Requests leave in the order they were queued, and the queue holds FIFO_DEPTH of them (default 4).
- R10: A recovery request that arrives while the queue is full is dropped, and `rec_ovf` pulses in the same cycle as its `div_viol`.
- R11: Transfers on consecutive cycles are each judged with the enable copy and automaton state left by the transfer before them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| base_addr | input | 32 | Base address of the guarded counter |
| evt_valid | input | 1 | Transfer present this cycle |
| evt_write | input | 1 | 1 = write, 0 = read |
| evt_addr | input | 32 | Transfer address |
| evt_data | input | 32 | Transfer data |
| rec_valid | output | 1 | Recovery request available |
| rec_ready | input | 1 | Master accepts the recovery request |
| rec_addr | output | 32 | Recovery write address |
| rec_data | output | 16 | Divisor value to restore |
| rec_be | output | 4 | Byte lanes of the recovery write |
| div_viol | output | 1 | Forbidden divisor change (pulse) |
| ctrl_viol | output | 1 | Forbidden control change (pulse) |
| rec_ovf | output | 1 | Recovery request dropped (pulse) |

## Verification
A sequence of transfers drives the guard through legal and illegal divisor writes, writes that repeat the shadow value, reads, and writes to unrelated offsets. This shows whether the enable copy, the shadow and the address decode respond only to what they should. The control writes cover enable then modify, a second modify after a flag, and enable then disable. These patterns tell apart an automaton that resets after a violation from one that stays armed. Transfers on consecutive cycles test that each event sees the state its predecessor left. A stalled master with five queued restores tests the queue's hold, its depth, and the overflow pulse.

// File: rtl/rgm_pkg.sv
package rgm_pkg;
  typedef enum logic {
    DFA_IDLE  = 1'b0,
    DFA_ARMED = 1'b1
  } dfa_state_t;

  typedef enum logic [1:0] {
    CEV_NONE    = 2'd0,
    CEV_ENABLE  = 2'd1,
    CEV_DISABLE = 2'd2,
    CEV_MODIFY  = 2'd3
  } ctrl_event_t;

  function automatic ctrl_event_t classify(input logic hit, input logic en_now, input logic en_new);
    if (!hit) return CEV_NONE;
    if (!en_now && en_new) return CEV_ENABLE;
    if (en_now && !en_new) return CEV_DISABLE;
    return CEV_MODIFY;
  endfunction
endpackage

// File: rtl/rgm_decode.sv
module rgm_decode #(
  parameter int AW = 32,
  parameter int DW = 32,
  parameter logic [AW-1:0] CTRL_OFS = 'h220,
  parameter logic [AW-1:0] DIV_OFS  = 'h228
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] base_addr,
  input  logic          evt_valid,
  input  logic          evt_write,
  input  logic [AW-1:0] evt_addr,
  input  logic [DW-1:0] evt_data,
  output logic          hit_ctrl_q,
  output logic          hit_div_q,
  output logic [DW-1:0] data_q,
  output logic [AW-1:0] div_addr_q
);
  logic          wr_evt;
  logic [AW-1:0] ctrl_addr;
  logic [AW-1:0] div_addr;

  assign wr_evt    = evt_valid & evt_write;
  assign ctrl_addr = base_addr + CTRL_OFS;
  assign div_addr  = base_addr + DIV_OFS;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hit_ctrl_q <= 1'b0;
      hit_div_q  <= 1'b0;
      data_q     <= '0;
      div_addr_q <= '0;
    end else begin
      hit_ctrl_q <= wr_evt && (evt_addr == ctrl_addr);
      hit_div_q  <= wr_evt && (evt_addr == div_addr);
      data_q     <= evt_data;
      div_addr_q <= div_addr;
    end
  end
endmodule

// File: rtl/rgm_ctrl_fsm.sv
module rgm_ctrl_fsm
  import rgm_pkg::*;
#(
  parameter int DW     = 32,
  parameter int EN_BIT = 0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          hit_ctrl,
  input  logic [DW-1:0] data,
  output logic          en_q,
  output logic          ctrl_viol_q
);
  dfa_state_t  st_q, st_d;
  ctrl_event_t ev;
  logic        viol_d;

  assign ev = classify(hit_ctrl, en_q, data[EN_BIT]);

  always_comb begin
    st_d   = st_q;
    viol_d = 1'b0;
    unique case (st_q)
      DFA_IDLE: begin
        if (ev == CEV_ENABLE) st_d = DFA_ARMED;
      end
      DFA_ARMED: begin
        if (ev == CEV_MODIFY) begin
          viol_d = 1'b1;
          st_d   = DFA_IDLE;
        end else if (ev == CEV_DISABLE) begin
          st_d = DFA_IDLE;
        end
      end
      default: st_d = DFA_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q        <= DFA_IDLE;
      en_q        <= 1'b0;
      ctrl_viol_q <= 1'b0;
    end else begin
      st_q        <= st_d;
      ctrl_viol_q <= viol_d;
      if (hit_ctrl) en_q <= data[EN_BIT];
    end
  end
endmodule

// File: rtl/rgm_div_guard.sv
module rgm_div_guard #(
  parameter int DW    = 32,
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hit_div,
  input  logic [DW-1:0]    data,
  input  logic             en,
  output logic             push,
  output logic [DIV_W-1:0] shadow_q,
  output logic             div_viol_q
);
  logic [DIV_W-1:0] new_div;

  assign new_div = data[DIV_W-1:0];
  assign push    = hit_div && en && (new_div != shadow_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      shadow_q   <= '0;
      div_viol_q <= 1'b0;
    end else begin
      div_viol_q <= push;
      if (hit_div && !push) shadow_q <= new_div;
    end
  end
endmodule

// File: rtl/rgm_rec_fifo.sv
module rgm_rec_fifo #(
  parameter int W     = 48,
  parameter int DEPTH = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] din,
  input  logic         ready,
  output logic         valid,
  output logic [W-1:0] dout,
  output logic         ovf_q
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [PW-1:0] LAST = PW'(DEPTH - 1);
  localparam logic [CW-1:0] FULL = CW'(DEPTH);

  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] wp_q, rp_q;
  logic [CW-1:0] cnt_q;
  logic          full, wr_ok, rd_ok;

  assign full  = (cnt_q == FULL);
  assign valid = (cnt_q != '0);
  assign dout  = mem[rp_q];
  assign wr_ok = push && !full;
  assign rd_ok = valid && ready;

  always_ff @(posedge clk) begin
    if (wr_ok) mem[wp_q] <= din;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
      ovf_q <= 1'b0;
    end else begin
      ovf_q <= push && full;
      if (wr_ok) wp_q <= (wp_q == LAST) ? '0 : wp_q + 1'b1;
      if (rd_ok) rp_q <= (rp_q == LAST) ? '0 : rp_q + 1'b1;
      case ({wr_ok, rd_ok})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end
endmodule

// File: rtl/reg_guard_mon.sv
module reg_guard_mon #(
  parameter int AW         = 32,
  parameter int DW         = 32,
  parameter int DIV_W      = 16,
  parameter int EN_BIT     = 0,
  parameter int FIFO_DEPTH = 4,
  parameter logic [AW-1:0] CTRL_OFS = 'h220,
  parameter logic [AW-1:0] DIV_OFS  = 'h228
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [AW-1:0]    base_addr,
  input  logic             evt_valid,
  input  logic             evt_write,
  input  logic [AW-1:0]    evt_addr,
  input  logic [DW-1:0]    evt_data,
  output logic             rec_valid,
  input  logic             rec_ready,
  output logic [AW-1:0]    rec_addr,
  output logic [DIV_W-1:0] rec_data,
  output logic [DW/8-1:0]  rec_be,
  output logic             div_viol,
  output logic             ctrl_viol,
  output logic             rec_ovf
);
  localparam int BE_W   = DW / 8;
  localparam int DIV_BY = DIV_W / 8;
  localparam int ENT_W  = AW + DIV_W;

  logic             hit_ctrl, hit_div, en, push;
  logic [DW-1:0]    data;
  logic [AW-1:0]    div_addr;
  logic [DIV_W-1:0] shadow;
  logic [ENT_W-1:0] head;

  rgm_decode #(.AW(AW), .DW(DW), .CTRL_OFS(CTRL_OFS), .DIV_OFS(DIV_OFS)) u_dec (
    .clk(clk), .rst_n(rst_n), .base_addr(base_addr),
    .evt_valid(evt_valid), .evt_write(evt_write), .evt_addr(evt_addr), .evt_data(evt_data),
    .hit_ctrl_q(hit_ctrl), .hit_div_q(hit_div), .data_q(data), .div_addr_q(div_addr)
  );

  rgm_ctrl_fsm #(.DW(DW), .EN_BIT(EN_BIT)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .hit_ctrl(hit_ctrl), .data(data),
    .en_q(en), .ctrl_viol_q(ctrl_viol)
  );

  rgm_div_guard #(.DW(DW), .DIV_W(DIV_W)) u_div (
    .clk(clk), .rst_n(rst_n), .hit_div(hit_div), .data(data), .en(en),
    .push(push), .shadow_q(shadow), .div_viol_q(div_viol)
  );

  rgm_rec_fifo #(.W(ENT_W), .DEPTH(FIFO_DEPTH)) u_fifo (
    .clk(clk), .rst_n(rst_n), .push(push), .din({div_addr, shadow}),
    .ready(rec_ready), .valid(rec_valid), .dout(head), .ovf_q(rec_ovf)
  );

  assign rec_addr = head[ENT_W-1:DIV_W];
  assign rec_data = head[DIV_W-1:0];

  for (genvar i = 0; i < BE_W; i++) begin : g_be
    assign rec_be[i] = (i < DIV_BY);
  end
endmodule

// File: rtl/rgm_checker.sv
module rgm_checker #(
  parameter int AW    = 32,
  parameter int DIV_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             evt_valid,
  input logic             rec_valid,
  input logic             rec_ready,
  input logic [AW-1:0]    rec_addr,
  input logic [DIV_W-1:0] rec_data,
  input logic             div_viol,
  input logic             ctrl_viol,
  input logic             rec_ovf
);
  p_hold_payload_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rec_valid && !rec_ready |=> rec_valid && $stable(rec_data) && $stable(rec_addr));

  p_viol_queues_r4: assert property (@(posedge clk) disable iff (!rst_n)
    div_viol |-> rec_valid);

  p_ovf_with_viol_r10: assert property (@(posedge clk) disable iff (!rst_n)
    rec_ovf |-> div_viol);

  p_div_latency_r8: assert property (@(posedge clk) disable iff (!rst_n)
    div_viol |-> $past(evt_valid, 2));

  p_ctrl_latency_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_viol |-> $past(evt_valid, 2));

  p_ctrl_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_viol |=> !ctrl_viol || $past(evt_valid, 1));
endmodule

bind reg_guard_mon rgm_checker #(.AW(AW), .DIV_W(DIV_W)) u_chk (.*);

// File: tb/reg_guard_mon_tb_top.sv
`timescale 1ns/1ps
module reg_guard_mon_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [31:0] base_addr, evt_addr, evt_data;
  logic        evt_valid, evt_write, rec_ready;
  logic        rec_valid, div_viol, ctrl_viol, rec_ovf;
  logic [31:0] rec_addr;
  logic [15:0] rec_data;
  logic [3:0]  rec_be;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  reg_guard_mon dut_i (
    .clk(clk), .rst_n(rst_n), .base_addr(base_addr),
    .evt_valid(evt_valid), .evt_write(evt_write), .evt_addr(evt_addr), .evt_data(evt_data),
    .rec_valid(rec_valid), .rec_ready(rec_ready), .rec_addr(rec_addr), .rec_data(rec_data),
    .rec_be(rec_be), .div_viol(div_viol), .ctrl_viol(ctrl_viol), .rec_ovf(rec_ovf)
  );

  localparam logic [31:0] BASE = 32'h0000_1000;
  localparam int NV = 17;
  // {write, offset[11:0], data[15:0], exp_div_viol, exp_ctrl_viol, exp_restore[15:0]}
  localparam logic [46:0] VEC [NV] = '{
    {1'b1, 12'h228, 16'h0010, 1'b0, 1'b0, 16'h0000},  // R5 legal divisor while off
    {1'b1, 12'h220, 16'h0001, 1'b0, 1'b0, 16'h0000},  // R3 enable
    {1'b1, 12'h228, 16'h0020, 1'b1, 1'b0, 16'h0010},  // R4 change while on
    {1'b1, 12'h228, 16'h0010, 1'b0, 1'b0, 16'h0000},  // R5 same as shadow
    {1'b1, 12'h220, 16'h0003, 1'b0, 1'b1, 16'h0000},  // R6 modify after enable
    {1'b1, 12'h220, 16'h0005, 1'b0, 1'b0, 16'h0000},  // R7 back in start state
    {1'b1, 12'h220, 16'h0000, 1'b0, 1'b0, 16'h0000},  // R3 disable
    {1'b1, 12'h228, 16'h0030, 1'b0, 1'b0, 16'h0000},  // R5 legal
    {1'b0, 12'h220, 16'h0001, 1'b0, 1'b0, 16'h0000},  // R2 read ignored
    {1'b1, 12'h228, 16'h0040, 1'b0, 1'b0, 16'h0000},  // R2 still disabled
    {1'b1, 12'h220, 16'h0001, 1'b0, 1'b0, 16'h0000},  // enable
    {1'b1, 12'h220, 16'h0000, 1'b0, 1'b0, 16'h0000},  // R7 enable then disable
    {1'b1, 12'h220, 16'h0001, 1'b0, 1'b0, 16'h0000},  // enable
    {1'b1, 12'h228, 16'h0055, 1'b1, 1'b0, 16'h0040},  // R4
    {1'b1, 12'h224, 16'h0000, 1'b0, 1'b0, 16'h0000},  // R2 other offset ignored
    {1'b1, 12'h228, 16'h0066, 1'b1, 1'b0, 16'h0040},  // R4 shadow kept
    {1'b1, 12'h220, 16'h0000, 1'b0, 1'b0, 16'h0000}   // R7 disable, no flag
  };

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic drive(input bit w, input logic [11:0] ofs, input logic [15:0] d);
    evt_valid = 1'b1;
    evt_write = w;
    evt_addr  = BASE + {20'h0, ofs};
    evt_data  = {16'h0, d};
  endtask

  task automatic idle();
    evt_valid = 1'b0;
    evt_write = 1'b0;
    evt_addr  = '0;
    evt_data  = '0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 20);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=%h expected=%h", 0, 1);
    finish_run();
  end

  initial begin
    int seen_ctrl, seen_div, pops;
    logic [15:0] d0;
    base_addr = BASE;
    rec_ready = 1'b1;
    rst_n     = 1'b0;
    idle();
    repeat (3) @(negedge clk);
    // R1 reset state
    chk({div_viol, ctrl_viol, rec_ovf, rec_valid} == 4'b0, "R1 reset outputs", {28'h0, div_viol, ctrl_viol, rec_ovf, rec_valid}, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // Table walk: drive at negedge, check two rising edges later (R8)
    for (int i = 0; i < NV; i++) begin
      logic [46:0] v;
      v = VEC[i];
      drive(v[46], v[45:34], v[33:18]);
      @(negedge clk);
      idle();
      @(negedge clk);
      chk(div_viol == v[17], "R4 R5 R8 div_viol", {31'h0, div_viol}, {31'h0, v[17]});
      chk(ctrl_viol == v[16], "R6 R7 R8 ctrl_viol", {31'h0, ctrl_viol}, {31'h0, v[16]});
      chk(rec_valid == v[17], "R4 R8 rec_valid", {31'h0, rec_valid}, {31'h0, v[17]});
      if (v[17]) begin
        chk(rec_data == v[15:0], "R4 restore data", {16'h0, rec_data}, {16'h0, v[15:0]});
        chk(rec_addr == BASE + 32'h228, "R4 restore addr", rec_addr, BASE + 32'h228);
        chk(rec_be == 4'b0011, "R4 byte lanes", {28'h0, rec_be}, 32'h3);
      end
    end

    // R9 R10: stalled master, five illegal writes into a 4-deep queue
    rec_ready = 1'b0;
    drive(1'b1, 12'h220, 16'h0001);
    @(negedge clk);
    for (int k = 0; k < 5; k++) begin
      drive(1'b1, 12'h228, 16'h0101 + 16'(k));
      @(negedge clk);
    end
    idle();
    @(negedge clk);
    chk(rec_ovf == 1'b1, "R10 overflow pulse", {31'h0, rec_ovf}, 1);
    @(negedge clk);
    chk(rec_ovf == 1'b0, "R10 overflow single cycle", {31'h0, rec_ovf}, 0);
    d0 = rec_data;
    repeat (3) @(negedge clk);
    chk(rec_valid && rec_data == d0, "R9 hold while stalled", {15'h0, rec_valid, rec_data}, {15'h0, 1'b1, d0});
    rec_ready = 1'b1;
    pops = 0;
    for (int k = 0; k < 8; k++) begin
      if (rec_valid) begin
        pops++;
        chk(rec_data == 16'h0040, "R9 drained value", {16'h0, rec_data}, 32'h40);
      end
      @(negedge clk);
    end
    chk(pops == 4, "R9 R10 queue depth", pops, 4);

    // R1 R11: reset, then back-to-back enable, modify, divisor change
    rst_n = 1'b0;
    @(negedge clk);
    @(negedge clk);
    chk({div_viol, ctrl_viol, rec_ovf, rec_valid} == 4'b0, "R1 reset again", {28'h0, div_viol, ctrl_viol, rec_ovf, rec_valid}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    drive(1'b1, 12'h220, 16'h0001);
    @(negedge clk);
    drive(1'b1, 12'h220, 16'h0003);
    @(negedge clk);
    drive(1'b1, 12'h228, 16'h0077);
    @(negedge clk);
    idle();
    seen_ctrl = 0;
    seen_div  = 0;
    for (int k = 0; k < 4; k++) begin
      if (ctrl_viol) seen_ctrl++;
      if (div_viol) begin
        seen_div++;
        chk(rec_data == 16'h0000, "R1 shadow reset value", {16'h0, rec_data}, 0);
      end
      @(negedge clk);
    end
    chk(seen_ctrl == 1, "R11 back-to-back control flag", seen_ctrl, 1);
    chk(seen_div == 1, "R11 back-to-back divisor flag", seen_div, 1);

    finish_run();
  end
endmodule